// File: doc/BRIEF.md
# Outbound Byte Staging Path for a Parallel SCSI Data Bus

This block holds outbound bytes on their way from a host-side DMA write port to a parallel SCSI data bus. Every byte enters through one visible holding latch. In synchronous transfers the byte then moves into a second, hidden register, and only that register feeds the bus. In asynchronous transfers the latch feeds the bus directly and the hidden register stays empty. The DMA side can therefore have up to two bytes inside the block in synchronous mode and one byte in asynchronous mode.

The bus side uses a valid/accept handshake. Signalling on the SCSI wires is handled elsewhere. The block reports whether the latch and the hidden register are occupied, and it gives the number of resident bytes. After a transfer error, firmware reads that count to find how many bytes never reached the bus. A synchronous flush empties both stages. A mode change requested while bytes are resident is held off until the path is empty.

Top module: `osp_out_path`

## Requirements
- R1: After reset both stages are empty, `resident_cnt_o` is 0, `bus_valid_o` is 0, `wr_ready_o` is 1 and the effective mode `mode_o` is synchronous (1).
- R2: `latch_full_o` is 1 exactly while the visible latch holds a byte. A write is taken on a cycle where `wr_valid_i` and `wr_ready_o` are both 1, and a held byte is never overwritten.
- R3: With `mode_o`=1 a byte passes from the latch into the hidden register, and `bus_valid_o`/`bus_data_o` come only from the hidden register. On an empty path a byte written in cycle n shows in the latch at n+1 and on the bus at n+2.
- R4: With `mode_o`=0 `bus_valid_o`/`bus_data_o` come directly from the latch, and `hidden_full_o` stays 0.
- R5: `resident_cnt_o` equals the number of occupied stages: 0, 1 or 2.
- R6: The latch takes a new byte in the same cycle that its current byte leaves, whether it moves to the hidden register in synchronous mode or is accepted by the bus in asynchronous mode.
- R7: A cycle with `flush_i`=1 empties both stages by the next cycle. A write offered in that cycle is dropped, and `wr_ready_o` is 0 during it.
- R8: `mode_o` takes the value of `sync_mode_i` on the clock edge that ends a cycle in which both stages are empty. While any byte is resident, changes of `sync_mode_i` are ignored.
- R9: A byte leaves the bus side only on a cycle where `bus_accept_i` is 1. While `bus_valid_o` is 1 and not accepted, `bus_data_o` holds.
- R10: Bytes reach the bus in the order in which they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous clear of both stages |
| sync_mode_i | input | 1 | Requested mode: 1 synchronous, 0 asynchronous |
| wr_valid_i | input | 1 | Host byte offered |
| wr_data_i | input | DATA_W | Host byte |
| wr_ready_o | output | 1 | Latch can take a byte this cycle |
| bus_valid_o | output | 1 | Byte presented to the bus side |
| bus_data_o | output | DATA_W | Byte presented to the bus side |
| bus_accept_i | input | 1 | Bus side takes the presented byte |
| latch_full_o | output | 1 | Visible latch occupied |
| hidden_full_o | output | 1 | Hidden register occupied |
| resident_cnt_o | output | 2 | Bytes held inside the block |
| mode_o | output | 1 | Mode currently in effect |

## Verification
Two events can fall in the same cycle: the latch taking a host byte, and its old byte leaving it, either into the hidden register or out through an accept. The random stimulus keeps `wr_valid_i` high most of the time with a full latch, while `bus_accept_i` toggles. Directed steps do the same with fixed bytes. Each cycle the bench compares the ready flag, the occupancy flags and the presented byte with a bench model. Any byte lost or duplicated in that overlap shows up as a wrong byte order on the bus or a wrong count. Flushes and mode requests are mixed into the same traffic, so they also land on those overlap cycles.

// File: rtl/osp_pkg.sv
package osp_pkg;
    typedef enum logic {
        MODE_ASYNC = 1'b0,
        MODE_SYNC  = 1'b1
    } xfer_mode_e;

    localparam int unsigned STAGES_MAX = 2;
    localparam int unsigned CNT_W      = $clog2(STAGES_MAX + 1);
endpackage

// File: rtl/osp_stage.sv
module osp_stage #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              unload_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.full = 1'b0;
        end else if (load_i) begin
            st_d.full = 1'b1;
            st_d.data = load_data_i;
        end else if (unload_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o = st_q.full;
    assign data_o = st_q.data;

    // a held byte is never replaced unless it leaves in the same cycle
    assert_no_overwrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !unload_i && !flush_i) |-> !load_i);

    // flush empties the stage on the next edge
    assert_stage_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !full_o);
endmodule

// File: rtl/osp_mode_ctl.sv
module osp_mode_ctl
    import osp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy_i,
    input  logic       req_sync_i,
    output xfer_mode_e mode_o
);
    typedef struct packed {
        xfer_mode_e mode;
    } mctl_t;

    mctl_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (!busy_i) begin
            m_d.mode = req_sync_i ? MODE_SYNC : MODE_ASYNC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.mode <= MODE_SYNC;
        end else begin
            m_q <= m_d;
        end
    end

    assign mode_o = m_q.mode;

    // mode frozen while any byte is resident
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (mode_o == $past(mode_o)));
endmodule

// File: rtl/osp_out_path.sv
module osp_out_path
    import osp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              sync_mode_i,
    input  logic              wr_valid_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              wr_ready_o,
    output logic              bus_valid_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic              bus_accept_i,
    output logic              latch_full_o,
    output logic              hidden_full_o,
    output logic [CNT_W-1:0]  resident_cnt_o,
    output logic              mode_o
);
    xfer_mode_e        mode_q;
    logic              is_sync;
    logic              lat_full, hid_full;
    logic [DATA_W-1:0] lat_data, hid_data;
    logic              hid_room, move, lat_unload, hid_unload, lat_load;

    // control for the current cycle
    always_comb begin
        is_sync    = (mode_q == MODE_SYNC);
        hid_unload = is_sync && hid_full && bus_accept_i;
        hid_room   = !hid_full || bus_accept_i;
        move       = is_sync && lat_full && hid_room;
        lat_unload = is_sync ? move : (lat_full && bus_accept_i);
        wr_ready_o = !flush_i && (!lat_full || lat_unload);
        lat_load   = wr_valid_i && wr_ready_o;
        bus_valid_o = is_sync ? hid_full : lat_full;
        bus_data_o  = is_sync ? hid_data : lat_data;
    end

    osp_stage #(.DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .load_i     (lat_load),
        .load_data_i(wr_data_i),
        .unload_i   (lat_unload),
        .full_o     (lat_full),
        .data_o     (lat_data)
    );

    osp_stage #(.DATA_W(DATA_W)) u_hidden (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .load_i     (move),
        .load_data_i(lat_data),
        .unload_i   (hid_unload),
        .full_o     (hid_full),
        .data_o     (hid_data)
    );

    osp_mode_ctl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_i    (lat_full || hid_full),
        .req_sync_i(sync_mode_i),
        .mode_o    (mode_q)
    );

    assign latch_full_o   = lat_full;
    assign hidden_full_o  = hid_full;
    assign resident_cnt_o = CNT_W'(lat_full) + CNT_W'(hid_full);
    assign mode_o         = mode_q;

    // asynchronous transfers never park a byte in the hidden register
    assert_async_no_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ASYNC) |-> !hid_full);

    // in synchronous mode the bus only sees the hidden register
    assert_sync_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sync && bus_valid_o) |-> hidden_full_o);

    // unaccepted byte stays put on the bus side
    assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && !bus_accept_i && !flush_i) |=> (bus_valid_o && $stable(bus_data_o)));

    // flush leaves nothing resident
    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (resident_cnt_o == '0));
endmodule

// File: tb/sim_osp_out_path.sv
module sim_osp_out_path;
    localparam int unsigned DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic          sync_mode_i = 1'b1;
    logic          wr_valid_i = 1'b0;
    logic [DW-1:0] wr_data_i = '0;
    logic          wr_ready_o, bus_valid_o, bus_accept_i = 1'b0;
    logic [DW-1:0] bus_data_o;
    logic          latch_full_o, hidden_full_o, mode_o;
    logic [1:0]    resident_cnt_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model state
    bit      m_lf, m_hf, m_mode;
    bit [7:0] m_ld, m_hd;

    always #2.5 clk = ~clk;

    osp_out_path #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .sync_mode_i(sync_mode_i),
        .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o),
        .bus_valid_o(bus_valid_o), .bus_data_o(bus_data_o), .bus_accept_i(bus_accept_i),
        .latch_full_o(latch_full_o), .hidden_full_o(hidden_full_o),
        .resident_cnt_o(resident_cnt_o), .mode_o(mode_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_valid();
        return m_mode ? m_hf : m_lf;
    endfunction
    function automatic bit [7:0] exp_data();
        return m_mode ? m_hd : m_ld;
    endfunction
    function automatic bit exp_move(input bit acc);
        return m_mode && m_lf && (!m_hf || acc);
    endfunction
    function automatic bit exp_lat_leave(input bit acc);
        return m_mode ? exp_move(acc) : (m_lf && acc);
    endfunction
    function automatic bit exp_ready(input bit fl, input bit acc);
        return !fl && (!m_lf || exp_lat_leave(acc));
    endfunction

    // one cycle: drive, compare, clock, advance model
    task automatic step(input bit wv, input bit [7:0] wd, input bit acc,
                        input bit fl, input bit md);
        bit er, mv, ll, busy;
        @(negedge clk);
        wr_valid_i = wv; wr_data_i = wd; bus_accept_i = acc;
        flush_i = fl; sync_mode_i = md;
        #1;
        er = exp_ready(fl, acc);
        chk(fl ? "R7 ready" : "R6 ready", wr_ready_o, er);
        chk(m_mode ? "R3 valid" : "R4 valid", bus_valid_o, exp_valid());
        if (exp_valid()) chk("R10 data", bus_data_o, exp_data());
        chk("R2 latch_full", latch_full_o, m_lf);
        chk("R4 hidden_full", hidden_full_o, m_hf);
        chk("R5 count", resident_cnt_o, m_lf + m_hf);
        chk("R8 mode", mode_o, m_mode);
        mv = exp_move(acc);
        ll = exp_lat_leave(acc);
        busy = m_lf || m_hf;
        @(posedge clk);
        if (fl) begin
            m_lf = 0; m_hf = 0;
        end else begin
            if (mv) begin m_hf = 1; m_hd = m_ld; end
            else if (m_mode && m_hf && acc) m_hf = 0;
            if (wv && er) begin m_lf = 1; m_ld = wd; end
            else if (ll) m_lf = 0;
        end
        if (!busy) m_mode = md;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_lf = 0; m_hf = 0; m_mode = 1; m_ld = 0; m_hd = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 cnt", resident_cnt_o, 0);
        chk("R1 valid", bus_valid_o, 0);
        chk("R1 ready", wr_ready_o, 1);
        chk("R1 mode", mode_o, 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 latency: byte written at n, latch at n+1, bus at n+2
        step(1, 8'hA5, 0, 0, 1);
        #1; chk("R3 latch n+1", latch_full_o, 1); chk("R3 bus n+1", bus_valid_o, 0);
        step(0, 8'h00, 0, 0, 1);
        #1; chk("R3 bus n+2", bus_valid_o, 1); chk("R3 data", bus_data_o, 8'hA5);
        // R6 fill latch behind hidden, then accept and load in one cycle
        step(1, 8'h11, 0, 0, 1);
        #1; chk("R5 two", resident_cnt_o, 2); chk("R2 full blocks", wr_ready_o, 0);
        step(1, 8'h22, 1, 0, 1);
        #1; chk("R10 order", bus_data_o, 8'h11); chk("R6 refill", latch_full_o, 1);
        // R9 hold without accept
        step(0, 8'h00, 0, 0, 1);
        #1; chk("R9 hold", bus_data_o, 8'h11);
        // R8 mode change while busy is ignored
        step(0, 8'h00, 0, 0, 0);
        #1; chk("R8 ignored", mode_o, 1);
        // R7 flush with a simultaneous write
        step(1, 8'h33, 0, 1, 1);
        #1; chk("R7 empty", resident_cnt_o, 0);
        // switch to async on an empty path
        step(0, 8'h00, 0, 0, 0);
        #1; chk("R8 switch", mode_o, 0);
        step(1, 8'h44, 0, 0, 0);
        #1; chk("R4 direct", bus_valid_o, 1); chk("R4 data", bus_data_o, 8'h44);
        step(1, 8'h55, 1, 0, 0);
        #1; chk("R6 async refill", bus_data_o, 8'h55); chk("R4 no hidden", hidden_full_o, 0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit wv, acc, fl, md;
            wv  = ($urandom % 100) < 75;
            acc = ($urandom % 100) < 50;
            fl  = ($urandom % 100) < 3;
            md  = (($urandom % 100) < 6) ? ~sync_mode_i : sync_mode_i;
            step(wv, 8'($urandom), acc, fl, md);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule